// File: doc/BRIEF.md
# Serial dual-rail clock-domain bridge

This block carries one data word from a sending clock domain to a receiving clock domain over three wires: two rails that together carry one phase-tagged bit symbol, and one return wire that carries the receiver's acknowledgement. Each bit is a two-rail symbol. The first rail holds the bit value. The exclusive-or of the two rails gives the symbol's phase. Moving from one phase to the other always flips exactly one rail, so either domain can sample the link at any time and still see either the old symbol or the new one.

The sender loads the word into a chain of symbol stages, one stage per bit, with the phases alternating. The chain then passes symbols one at a time to a chain of stages on the receiving side. A stage takes a new symbol only when that symbol's phase differs from its own and the following stage already holds the stage's current phase. Neither side counts bits. Each side decides that the word has been delivered by looking at the phase pattern held across its own chain. The two ready outputs are each resynchronised into their own clock.

Top module: `dr_serial_bridge`

## Requirements
- R1: When `src_start` is high for one `src_clk` cycle while `src_ready` is high, the block captures `src_data` and starts a transfer, and `src_ready` reads low from the following `src_clk` cycle.
- R2: Each symbol is a rail pair {value, check}, with phase = value XOR check. A captured word presets the sending stage for bit i with value `src_data[i]` and with phase 1 when (SRC_W-1-i) is even, otherwise phase 0. The stage nearest the link therefore holds phase 1.
- R3: With equal widths, when `snk_valid` rises, `snk_data` equals the captured `src_data`, with bit i landing in bit i.
- R4: `snk_valid` rises once the receiving stages hold alternating phases, with phase 1 in the stage farthest from the link. While `snk_valid` stays high and no release is given, `snk_data` does not change.
- R5: `src_ready` goes high again once every sending stage holds phase 0, and it stays high until the next accepted start.
- R6: A one-cycle `snk_release` pulse while `snk_valid` is high returns every receiving stage to phase 0. `snk_valid` is then low from the next `snk_clk` cycle and stays low until another word arrives.
- R7: A `snk_release` pulse while `snk_valid` is low is ignored, and the transfer in progress still delivers the correct word.
- R8: A `src_start` pulse while `src_ready` is low is ignored. It neither alters the word in flight nor launches an extra word.
- R9: The acknowledge input of the last receiving stage is fixed at phase 0, so a delivered word is held. A word launched in the meantime waits in the chains and appears only after `snk_release`.
- R10: Either reset returns that side's stages to phase 0 and holds its ready output low. After `src_rst` is released, `src_ready` goes high on the second `src_clk` edge (two-stage synchroniser). `snk_valid` stays low after `snk_rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Sending-side clock |
| src_rst | input | 1 | Sending-side synchronous reset, active high |
| src_start | input | 1 | One-cycle request to send `src_data` |
| src_data | input | SRC_W | Word to send |
| src_ready | output | 1 | Sender idle; a new start is accepted |
| snk_clk | input | 1 | Receiving-side clock |
| snk_rst | input | 1 | Receiving-side synchronous reset, active high |
| snk_release | input | 1 | One-cycle pulse freeing the receiver for the next word |
| snk_data | output | SNK_W | Received word, valid while `snk_valid` is high |
| snk_valid | output | 1 | A complete word is held |

## Verification
A wrong stage state usually does not show as a wrong bit. It shows as a handshake that never finishes. A lost or duplicated symbol leaves the phase pattern on one side incomplete, so `snk_valid` or `src_ready` never rises, and only the bench timeouts catch it, after hundreds of cycles. A preset with the wrong phase or order, or an early release that is not ignored, does complete. It then appears as a wrong `snk_data` word on the first rising edge of `snk_valid`. A receiver that does not hold its word, or a start that is not ignored, appears within one to a few hundred cycles as a changed `snk_data` or as an extra `snk_valid` after release.

// File: rtl/drsb_pkg.sv
package drsb_pkg;

   // Rail pair: [1] value rail, [0] check rail. Phase is their XOR.
   typedef logic [1:0] rail_pair_t;

   localparam rail_pair_t RAIL_IDLE = 2'b00;

   function automatic logic rail_phase(input rail_pair_t r);
      return r[1] ^ r[0];
   endfunction

   function automatic rail_pair_t rail_encode(input logic v, input logic ph);
      return {v, v ^ ph};
   endfunction

endpackage

// File: rtl/drsb_sync.sv
module drsb_sync #(
   parameter int LEN = 2,
   parameter int W   = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         flush,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int TOT = LEN * W;

   logic [TOT-1:0] pipe;

   always_ff @(posedge clk) begin
      if (rst || flush) pipe <= '0;
      else              pipe <= {pipe[TOT-W-1:0], d};
   end

   assign q = pipe[TOT-1 -: W];
endmodule

// File: rtl/drsb_chain.sv
module drsb_chain
   import drsb_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               flush,
   input  logic               load,
   input  logic [2*DEPTH-1:0] load_syms,
   input  rail_pair_t         head_in,
   input  logic               tail_ack,
   output logic [2*DEPTH-1:0] syms
);
   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      rail_pair_t cur;
      rail_pair_t feed;
      logic       next_ph;

      if (k == 0) begin : g_head
         assign feed = head_in;
      end else begin : g_body
         assign feed = syms[2*k-2 +: 2];
      end

      if (k == DEPTH - 1) begin : g_tail
         assign next_ph = tail_ack;
      end else begin : g_mid
         assign next_ph = rail_phase(syms[2*k+2 +: 2]);
      end

      always_ff @(posedge clk) begin
         if (rst || flush)
            cur <= RAIL_IDLE;
         else if (load)
            cur <= load_syms[2*k +: 2];
         else if ((rail_phase(feed) != rail_phase(cur)) && (rail_phase(cur) == next_ph))
            cur <= feed;
      end

      assign syms[2*k +: 2] = cur;
   end
endmodule

// File: rtl/drsb_phase_match.sv
module drsb_phase_match
   import drsb_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter bit ALTERNATE = 1'b0
) (
   input  logic [2*DEPTH-1:0] syms,
   output logic               hit
);
   function automatic logic [DEPTH-1:0] alt_pattern();
      logic [DEPTH-1:0] p;
      for (int i = 0; i < DEPTH; i++) p[i] = (((DEPTH - 1 - i) % 2) == 0);
      return p;
   endfunction

   localparam logic [DEPTH-1:0] ALT_PAT = alt_pattern();

   logic [DEPTH-1:0] ph;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ph
      assign ph[i] = rail_phase(syms[2*i +: 2]);
   end

   if (ALTERNATE) begin : g_alt
      assign hit = (ph == ALT_PAT);
   end else begin : g_zero
      assign hit = ~|ph;
   end
endmodule

// File: rtl/dr_serial_bridge.sv
module dr_serial_bridge
   import drsb_pkg::*;
#(
   parameter int SRC_W    = 16,
   parameter int SNK_W    = 16,
   parameter int SYNC_LEN = 2
) (
   input  logic             src_clk,
   input  logic             src_rst,
   input  logic             src_start,
   input  logic [SRC_W-1:0] src_data,
   output logic             src_ready,
   input  logic             snk_clk,
   input  logic             snk_rst,
   input  logic             snk_release,
   output logic [SNK_W-1:0] snk_data,
   output logic             snk_valid
);
   localparam bool_widths_equal = (SRC_W == SNK_W);
   localparam int SRC_BITS = 2 * SRC_W;
   localparam int SNK_BITS = 2 * SNK_W;

   if (SRC_W < 2 || SNK_W < 2) begin : g_bad_width
      $error("dr_serial_bridge: widths must be at least 2");
   end
   if (!bool_widths_equal && (((SRC_W % 2) != 0) || ((SNK_W % 2) != 0))) begin : g_bad_mix
      $error("dr_serial_bridge: unequal widths must both be even");
   end
   if (SYNC_LEN < 2) begin : g_bad_sync
      $error("dr_serial_bridge: SYNC_LEN must be at least 2");
   end

   // ---------------- sending side ----------------
   logic [SRC_BITS-1:0] src_load;
   logic [SRC_BITS-1:0] src_syms;
   logic                src_accept;
   logic                src_done;
   logic                src_tail_ack;
   rail_pair_t          link_rails;

   assign src_accept = src_start && src_ready;

   for (genvar i = 0; i < SRC_W; i++) begin : g_preset
      localparam logic PH = (((SRC_W - 1 - i) % 2) == 0);
      assign src_load[2*i +: 2] = rail_encode(src_data[i], PH);
   end

   drsb_chain #(.DEPTH(SRC_W)) u_src_chain (
      .clk      (src_clk),
      .rst      (src_rst),
      .flush    (1'b0),
      .load     (src_accept),
      .load_syms(src_load),
      .head_in  (RAIL_IDLE),
      .tail_ack (src_tail_ack),
      .syms     (src_syms)
   );

   assign link_rails = src_syms[SRC_BITS-1 -: 2];

   drsb_phase_match #(.DEPTH(SRC_W), .ALTERNATE(1'b0)) u_src_match (
      .syms(src_syms),
      .hit (src_done)
   );

   drsb_sync #(.LEN(SYNC_LEN), .W(1)) u_src_ready_sync (
      .clk  (src_clk),
      .rst  (src_rst),
      .flush(src_accept),
      .d    (src_done),
      .q    (src_ready)
   );

   // ---------------- receiving side ----------------
   logic [SNK_BITS-1:0] snk_syms;
   logic [1:0]          snk_link;
   logic                snk_accept;
   logic                snk_done;
   logic                snk_head_ph;

   assign snk_accept = snk_release && snk_valid;

   drsb_sync #(.LEN(SYNC_LEN), .W(2)) u_rail_sync (
      .clk  (snk_clk),
      .rst  (snk_rst),
      .flush(1'b0),
      .d    (link_rails),
      .q    (snk_link)
   );

   drsb_chain #(.DEPTH(SNK_W)) u_snk_chain (
      .clk      (snk_clk),
      .rst      (snk_rst),
      .flush    (snk_accept),
      .load     (1'b0),
      .load_syms('0),
      .head_in  (snk_link),
      .tail_ack (1'b0),
      .syms     (snk_syms)
   );

   assign snk_head_ph = rail_phase(snk_syms[1:0]);

   drsb_sync #(.LEN(SYNC_LEN), .W(1)) u_ack_sync (
      .clk  (src_clk),
      .rst  (src_rst),
      .flush(1'b0),
      .d    (snk_head_ph),
      .q    (src_tail_ack)
   );

   drsb_phase_match #(.DEPTH(SNK_W), .ALTERNATE(1'b1)) u_snk_match (
      .syms(snk_syms),
      .hit (snk_done)
   );

   drsb_sync #(.LEN(SYNC_LEN), .W(1)) u_snk_valid_sync (
      .clk  (snk_clk),
      .rst  (snk_rst),
      .flush(snk_accept),
      .d    (snk_done),
      .q    (snk_valid)
   );

   for (genvar j = 0; j < SNK_W; j++) begin : g_out
      assign snk_data[j] = snk_syms[2*j+1];
   end
endmodule

// File: rtl/drsb_checker.sv
module drsb_checker #(
   parameter int SRC_W = 16,
   parameter int SNK_W = 16
) (
   input logic               src_clk,
   input logic               src_rst,
   input logic               src_start,
   input logic               src_ready,
   input logic [2*SRC_W-1:0] src_syms,
   input logic               snk_clk,
   input logic               snk_rst,
   input logic               snk_release,
   input logic               snk_valid,
   input logic [SNK_W-1:0]   snk_data,
   input logic [2*SNK_W-1:0] snk_syms
);
   logic src_head_ph;
   logic snk_tail_ph;

   assign src_head_ph = src_syms[2*SRC_W-1] ^ src_syms[2*SRC_W-2];
   assign snk_tail_ph = snk_syms[2*SNK_W-1] ^ snk_syms[2*SNK_W-2];

   AST_START_DROPS_READY: assert property (@(posedge src_clk) disable iff (src_rst)
      (src_start && src_ready) |=> !src_ready); // R1

   AST_PRESET_HEAD_PHASE: assert property (@(posedge src_clk) disable iff (src_rst)
      (src_start && src_ready) |=> src_head_ph); // R2

   AST_IDLE_CHAIN_STILL: assert property (@(posedge src_clk) disable iff (src_rst)
      (src_ready && !src_start) |=> $stable(src_syms)); // R5

   AST_HELD_WORD_STABLE: assert property (@(posedge snk_clk) disable iff (snk_rst)
      (snk_valid && !snk_release) |=> $stable(snk_data)); // R4

   AST_RELEASE_CLEARS: assert property (@(posedge snk_clk) disable iff (snk_rst)
      (snk_valid && snk_release) |=> (!snk_valid && (snk_syms == '0))); // R6

   AST_TAIL_BLOCKS: assert property (@(posedge snk_clk) disable iff (snk_rst)
      (snk_tail_ph && !(snk_valid && snk_release)) |=> snk_tail_ph); // R9
endmodule

bind dr_serial_bridge drsb_checker #(.SRC_W(SRC_W), .SNK_W(SNK_W)) u_drsb_checker (
   .src_clk    (src_clk),
   .src_rst    (src_rst),
   .src_start  (src_start),
   .src_ready  (src_ready),
   .src_syms   (src_syms),
   .snk_clk    (snk_clk),
   .snk_rst    (snk_rst),
   .snk_release(snk_release),
   .snk_valid  (snk_valid),
   .snk_data   (snk_data),
   .snk_syms   (snk_syms)
);

// File: tb/test_dr_serial_bridge.sv
`timescale 1ns/1ps
module test_dr_serial_bridge;
   localparam int W = 16;

   logic         src_clk = 1'b0;
   logic         snk_clk = 1'b0;
   logic         src_rst = 1'b1;
   logic         snk_rst = 1'b1;
   logic         src_start = 1'b0;
   logic [W-1:0] src_data = '0;
   logic         src_ready;
   logic         snk_release = 1'b0;
   logic [W-1:0] snk_data;
   logic         snk_valid;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5  src_clk = ~src_clk;
   always #3.65 snk_clk = ~snk_clk;

   dr_serial_bridge #(.SRC_W(W), .SNK_W(W), .SYNC_LEN(2)) i_dr_serial_bridge (
      .src_clk    (src_clk),
      .src_rst    (src_rst),
      .src_start  (src_start),
      .src_data   (src_data),
      .src_ready  (src_ready),
      .snk_clk    (snk_clk),
      .snk_rst    (snk_rst),
      .snk_release(snk_release),
      .snk_data   (snk_data),
      .snk_valid  (snk_valid)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Bench model: with equal widths the received word is the sent word.
   function automatic logic [W-1:0] expected_word(input logic [W-1:0] sent);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = sent[i];
      return r;
   endfunction

   task automatic send(input logic [W-1:0] w);
      @(negedge src_clk);
      src_start = 1'b1;
      src_data  = w;
      @(negedge src_clk);
      src_start = 1'b0;
      check(src_ready == 1'b0, "R1 ready low after start", 32'(src_ready), 32'd0);
   endtask

   task automatic wait_valid(output bit ok);
      ok = 1'b0;
      for (int n = 0; n < 3000; n++) begin
         @(negedge snk_clk);
         if (snk_valid) begin ok = 1'b1; break; end
      end
   endtask

   task automatic wait_src_ready(output bit ok);
      ok = 1'b0;
      for (int n = 0; n < 4000; n++) begin
         @(negedge src_clk);
         if (src_ready) begin ok = 1'b1; break; end
      end
   endtask

   task automatic release_word();
      @(negedge snk_clk);
      snk_release = 1'b1;
      @(negedge snk_clk);
      snk_release = 1'b0;
      check(snk_valid == 1'b0, "R6 valid low after release", 32'(snk_valid), 32'd0);
   endtask

   task automatic run_word(input logic [W-1:0] w, input bit early_rel, input bit dbl_start);
      bit ok;
      send(w);
      if (dbl_start) begin
         src_start = 1'b1;
         src_data  = ~w;
         @(negedge src_clk);
         src_start = 1'b0;
         check(src_ready == 1'b0, "R8 busy start leaves ready low", 32'(src_ready), 32'd0);
      end
      if (early_rel) begin
         repeat (2) @(negedge snk_clk);
         snk_release = 1'b1;
         @(negedge snk_clk);
         snk_release = 1'b0;
         check(snk_valid == 1'b0, "R7 no word yet", 32'(snk_valid), 32'd0);
      end
      wait_valid(ok);
      check(ok, "R4 valid rises", 32'(ok), 32'd1);
      check(snk_data == expected_word(w), "R3 received word", 32'(snk_data), 32'(expected_word(w)));
      repeat (5) @(negedge snk_clk);
      check(snk_valid && (snk_data == expected_word(w)), "R4 word held", 32'(snk_data), 32'(expected_word(w)));
      wait_src_ready(ok);
      check(ok, "R5 source ready returns", 32'(ok), 32'd1);
      repeat (4) @(negedge src_clk);
      check(src_ready == 1'b1, "R5 ready stays high", 32'(src_ready), 32'd1);
      release_word();
      if (dbl_start) begin
         repeat (300) @(negedge snk_clk);
         check(snk_valid == 1'b0, "R8 no extra word", 32'(snk_valid), 32'd0);
      end else begin
         repeat (20) @(negedge snk_clk);
         check(snk_valid == 1'b0, "R6 stays released", 32'(snk_valid), 32'd0);
      end
   endtask

   initial begin : watchdog
      #750000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      bit ok;
      logic [W-1:0] a_word;
      logic [W-1:0] b_word;
      logic [31:0]  r;
      r = $urandom(32'd20240611);

      // R10: reset behaviour
      repeat (10) @(negedge src_clk);
      check(src_ready == 1'b0, "R10 src_ready low in reset", 32'(src_ready), 32'd0);
      check(snk_valid == 1'b0, "R10 snk_valid low in reset", 32'(snk_valid), 32'd0);
      @(negedge snk_clk);
      snk_rst = 1'b0;
      @(negedge src_clk);
      src_rst = 1'b0;
      @(negedge src_clk);
      check(src_ready == 1'b0, "R10 ready after one edge", 32'(src_ready), 32'd0);
      @(negedge src_clk);
      check(src_ready == 1'b1, "R10 ready after two edges", 32'(src_ready), 32'd1);
      repeat (10) @(negedge snk_clk);
      check(snk_valid == 1'b0, "R10 snk_valid low after reset", 32'(snk_valid), 32'd0);

      // R2 R3: directed patterns
      run_word(16'h0000, 1'b0, 1'b0);
      run_word(16'hFFFF, 1'b0, 1'b0);
      run_word(16'hAAAA, 1'b1, 1'b0);
      run_word(16'h5555, 1'b0, 1'b1);
      run_word(16'h8001, 1'b0, 1'b0);

      // random words, some with early release or a busy start
      for (int n = 0; n < 14; n++) begin
         r = $urandom;
         run_word(r[W-1:0], (n % 4) == 1, (n % 5) == 2);
      end

      // R9: back-pressure while the receiver still holds a word
      a_word = 16'h1234;
      b_word = 16'hC3A5;
      send(a_word);
      wait_valid(ok);
      check(ok && snk_data == expected_word(a_word), "R9 first word", 32'(snk_data), 32'(a_word));
      wait_src_ready(ok);
      check(ok, "R5 ready before second word", 32'(ok), 32'd1);
      send(b_word);
      repeat (300) @(negedge snk_clk);
      check(snk_valid == 1'b1, "R9 first word still held", 32'(snk_valid), 32'd1);
      check(snk_data == expected_word(a_word), "R9 held data unchanged", 32'(snk_data), 32'(a_word));
      release_word();
      wait_valid(ok);
      check(ok && snk_data == expected_word(b_word), "R9 second word after release", 32'(snk_data), 32'(b_word));
      wait_src_ready(ok);
      check(ok, "R5 ready after second word", 32'(ok), 32'd1);
      release_word();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule